// File: doc/BRIEF.md
# Sign-Fill Line Expander

This block turns one stored data-cache line back into full-width words for the load path. Each word is held as a lower half-word and a sign bit. A small pool of overflow slots holds the upper halves of the few words that could not be shrunk, and a per-word flag marks each of those words. A single line-level bit says whether the line was stored in packed form at all. When the bit is clear, the whole upper half of the line comes from a second array read, which is supplied on its own port.

For every word the expander picks where the upper half comes from. There are three sources: a copy of the sign bit, one of the overflow slots, or the second array read. Only the stored flags steer this choice. Overflow slots are handed out in word order: counting up from word 0, the k-th flagged word owns slot k. The whole rebuilt line is registered, and so is one word chosen by an offset. The outputs appear one clock after the inputs. A status output tells the access controller that the line needs the extra cycle for the second array read.

Top module: `signfill_line_expander`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `line_o`, `word_o` and `right_needed_o` are all zero.
- R2: In every case, the lower half (bits [HALF_W-1:0]) of output word i equals the lower half-word i of `lo_half_i` from the previous clock. Word i sits at `line_o[i*2*HALF_W +: 2*HALF_W]`, and half-word i at `[i*HALF_W +: HALF_W]` of the half-word inputs.
- R3: In a packed line (`line_packed_i`=1), a word whose bit in `ovf_flag_i` is 0 gets an upper half made of HALF_W copies of its `sign_i` bit.
- R4: In a packed line, a flagged word with k flagged words below it, where k < SLOTS, gets its upper half from overflow slot k, which is `ovf_slot_i[k*HALF_W +: HALF_W]`.
- R5: In a packed line, a flagged word with SLOTS or more flagged words below it falls back to sign fill from its `sign_i` bit.
- R6: When `line_packed_i`=0, the upper half of word i is `right_half_i[i*HALF_W +: HALF_W]`. In that case the signs, flags and slots have no effect on the output.
- R7: `right_needed_o` is 1 one clock after `line_packed_i` was 0, and 0 one clock after it was 1.
- R8: `word_o` equals the rebuilt word i, where i is the value of `word_sel_i` on the previous clock.
- R9: A line packed by the matching rule is rebuilt exactly. Under that rule, a word is flagged when its upper half is neither all zeros nor all ones, the flagged upper halves fill slots in word order, and the sign bit is the top bit of the upper half. If more than SLOTS words are flagged, the line is stored unpacked with its upper halves in the second array read instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_half_i | input | WORDS*HALF_W | Stored lower half-words, word i at [i*HALF_W +: HALF_W] |
| sign_i | input | WORDS | Stored sign bit per word |
| ovf_slot_i | input | SLOTS*HALF_W | Overflow slots holding the upper halves that could not be shrunk |
| ovf_flag_i | input | WORDS | Marks each word whose upper half sits in an overflow slot |
| line_packed_i | input | 1 | Line is stored in packed form |
| right_half_i | input | WORDS*HALF_W | Upper half-words from the second array read |
| word_sel_i | input | SEL_W | Offset of the word driven on word_o |
| line_o | output | WORDS*2*HALF_W | Rebuilt line |
| word_o | output | 2*HALF_W | Rebuilt word at the selected offset |
| right_needed_o | output | 1 | The line needed the second array read |

## Verification
The bench builds the expander with WORDS=4, SLOTS=2 and HALF_W=16. This small setting makes it practical to sweep every one of the 16 flag patterns against every one of the 16 sign patterns in packed lines. The sweep therefore reaches each slot rank, plus the case where three or four flagged words exceed the two slots and fall back to sign fill. Unpacked lines are driven with flags, signs and slots set to random values, to show that those inputs are ignored. A round-trip pass packs random lines in the bench, both within and beyond the two-slot tolerance, and compares the rebuilt line with the original.

// File: rtl/sxd_pkg.sv
package sxd_pkg;

    localparam int unsigned HALF_W_DEF = 16;

    typedef enum logic [1:0] {
        UP_SIGN  = 2'd0,
        UP_SLOT  = 2'd1,
        UP_RIGHT = 2'd2
    } upper_src_e;

    function automatic int unsigned sel_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sxd_slot_rank.sv
module sxd_slot_rank #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned RANK_W = 4
) (
    input  logic [WORDS-1:0]        flag_i,
    output logic [WORDS*RANK_W-1:0] rank_o
);
    // Rank of word i: how many flagged words sit below it.
    always_comb begin : prefix_count
        logic [RANK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < WORDS; i++) begin
            rank_o[i*RANK_W +: RANK_W] = acc;
            acc = acc + {{(RANK_W-1){1'b0}}, flag_i[i]};
        end
    end
endmodule

// File: rtl/sxd_word_rebuild.sv
module sxd_word_rebuild
    import sxd_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter int unsigned SLOTS  = 2,
    parameter int unsigned RANK_W = 4
) (
    input  logic [HALF_W-1:0]       lo_i,
    input  logic                    sign_i,
    input  logic                    flag_i,
    input  logic                    packed_i,
    input  logic [HALF_W-1:0]       right_i,
    input  logic [RANK_W-1:0]       rank_i,
    input  logic [SLOTS*HALF_W-1:0] slots_i,
    output logic [2*HALF_W-1:0]     word_o,
    output upper_src_e              src_o
);
    logic [HALF_W-1:0] slot_data;
    logic              slot_hit;
    logic [HALF_W-1:0] upper;

    always_comb begin
        slot_data = '0;
        slot_hit  = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (rank_i == RANK_W'(s)) begin
                slot_data = slots_i[s*HALF_W +: HALF_W];
                slot_hit  = 1'b1;
            end
        end
    end

    always_comb begin
        if (!packed_i) begin
            src_o = UP_RIGHT;
            upper = right_i;
        end else if (flag_i && slot_hit) begin
            src_o = UP_SLOT;
            upper = slot_data;
        end else begin
            src_o = UP_SIGN;
            upper = {HALF_W{sign_i}};
        end
    end

    assign word_o = {upper, lo_i};
endmodule

// File: rtl/signfill_line_expander.sv
module signfill_line_expander
    import sxd_pkg::*;
#(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned SLOTS  = 2,
    parameter int unsigned HALF_W = HALF_W_DEF,
    parameter int unsigned SEL_W  = sel_bits(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [WORDS*HALF_W-1:0]   lo_half_i,
    input  logic [WORDS-1:0]          sign_i,
    input  logic [SLOTS*HALF_W-1:0]   ovf_slot_i,
    input  logic [WORDS-1:0]          ovf_flag_i,
    input  logic                      line_packed_i,
    input  logic [WORDS*HALF_W-1:0]   right_half_i,
    input  logic [SEL_W-1:0]          word_sel_i,
    output logic [WORDS*2*HALF_W-1:0] line_o,
    output logic [2*HALF_W-1:0]       word_o,
    output logic                      right_needed_o
);
    localparam int unsigned W2     = 2 * HALF_W;
    localparam int unsigned RANK_W = $clog2(WORDS + 1);

    logic [WORDS*RANK_W-1:0] rank;
    logic [WORDS*W2-1:0]     line_next;
    upper_src_e              src [WORDS];

    sxd_slot_rank #(.WORDS(WORDS), .RANK_W(RANK_W)) u_rank (
        .flag_i (ovf_flag_i),
        .rank_o (rank)
    );

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        sxd_word_rebuild #(.HALF_W(HALF_W), .SLOTS(SLOTS), .RANK_W(RANK_W)) u_word (
            .lo_i     (lo_half_i[i*HALF_W +: HALF_W]),
            .sign_i   (sign_i[i]),
            .flag_i   (ovf_flag_i[i]),
            .packed_i (line_packed_i),
            .right_i  (right_half_i[i*HALF_W +: HALF_W]),
            .rank_i   (rank[i*RANK_W +: RANK_W]),
            .slots_i  (ovf_slot_i),
            .word_o   (line_next[i*W2 +: W2]),
            .src_o    (src[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_o         <= '0;
            word_o         <= '0;
            right_needed_o <= 1'b0;
        end else begin
            line_o         <= line_next;
            word_o         <= line_next[word_sel_i*W2 +: W2];
            right_needed_o <= !line_packed_i;
        end
    end

    // R7
    right_needed_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (right_needed_o == !$past(line_packed_i)));

    // R8
    word_pick_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (word_o == line_o[$past(word_sel_i)*W2 +: W2]));

    for (genvar i = 0; i < WORDS; i++) begin : g_chk
        // R2
        low_pass_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (line_o[i*W2 +: HALF_W] == $past(lo_half_i[i*HALF_W +: HALF_W])));

        // R3
        sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
            (line_packed_i && !ovf_flag_i[i]) |=>
                (line_o[i*W2 + HALF_W +: HALF_W] == {HALF_W{$past(sign_i[i])}}));

        // R6
        right_src_chk: assert property (@(posedge clk) disable iff (rst)
            (!line_packed_i) |=>
                (line_o[i*W2 + HALF_W +: HALF_W] == $past(right_half_i[i*HALF_W +: HALF_W])));

        // R4
        slot_only_flagged_chk: assert property (@(posedge clk) disable iff (rst)
            (src[i] == UP_SLOT) |-> (line_packed_i && ovf_flag_i[i]));
    end
endmodule

// File: tb/tb_signfill_line_expander.sv
`timescale 1ns/1ps
module tb_signfill_line_expander;
    localparam int WORDS = 4;
    localparam int SLOTS = 2;
    localparam int HW    = 16;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [WORDS*HW-1:0]     lo_half;
    logic [WORDS-1:0]        sign;
    logic [SLOTS*HW-1:0]     slots;
    logic [WORDS-1:0]        flags;
    logic                    packed_l;
    logic [WORDS*HW-1:0]     right;
    logic [1:0]              sel;
    logic [WORDS*2*HW-1:0]   line_o;
    logic [2*HW-1:0]         word_o;
    logic                    right_needed;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    signfill_line_expander #(.WORDS(WORDS), .SLOTS(SLOTS), .HALF_W(HW)) dut (
        .clk(clk), .rst(rst), .lo_half_i(lo_half), .sign_i(sign), .ovf_slot_i(slots),
        .ovf_flag_i(flags), .line_packed_i(packed_l), .right_half_i(right),
        .word_sel_i(sel), .line_o(line_o), .word_o(word_o), .right_needed_o(right_needed)
    );

    function automatic logic [127:0] model(input logic [63:0] lo, input logic [3:0] sg,
                                           input logic [31:0] sl, input logic [3:0] fl,
                                           input logic pk, input logic [63:0] rt);
        logic [127:0] res;
        logic [15:0]  up;
        int k;
        k = 0;
        for (int i = 0; i < WORDS; i++) begin
            if (!pk)                    up = rt[i*16 +: 16];
            else if (fl[i] && k < SLOTS) up = sl[k*16 +: 16];
            else                        up = {16{sg[i]}};
            if (fl[i]) k++;
            res[i*32 +: 32] = {up, lo[i*16 +: 16]};
        end
        return res;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Apply at negedge, registered result is visible at the next negedge.
    task automatic apply_and_check(input string tag, input logic [127:0] expect_line);
        logic [31:0] ew;
        @(negedge clk);
        ew = expect_line[sel*32 +: 32];
        chk(line_o == expect_line, tag, line_o, expect_line);
        chk(word_o == ew, "R8 word select", word_o, ew);
        chk(right_needed == !packed_l, "R7 right needed", right_needed, !packed_l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] exp;
        logic [15:0]  up [WORDS];
        logic [63:0]  low_exp;
        rst = 1'b1; lo_half = '1; sign = '1; slots = '1; flags = '0;
        packed_l = 1'b0; right = '1; sel = '0;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero
        chk(line_o == '0 && word_o == '0 && right_needed == 1'b0, "R1 reset state",
            {line_o[95:0], word_o}, '0);
        rst = 1'b0;

        // R3 R4 R5: every flag pattern against every sign pattern
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 16; s++) begin
                lo_half  = {$urandom, $urandom};
                slots    = $urandom;
                right    = {$urandom, $urandom};
                flags    = 4'(f);
                sign     = 4'(s);
                packed_l = 1'b1;
                sel      = 2'((f + s) % 4);
                exp = model(lo_half, sign, slots, flags, 1'b1, right);
                apply_and_check("R3 R4 R5 packed line", exp);
                low_exp = lo_half;
                for (int i = 0; i < WORDS; i++)
                    chk(line_o[i*32 +: 16] == low_exp[i*16 +: 16], "R2 lower half",
                        line_o[i*32 +: 16], low_exp[i*16 +: 16]);
            end
        end

        // R6: unpacked lines ignore flags, signs and slots
        for (int n = 0; n < 40; n++) begin
            lo_half  = {$urandom, $urandom};
            slots    = $urandom;
            right    = {$urandom, $urandom};
            flags    = 4'($urandom);
            sign     = 4'($urandom);
            packed_l = 1'b0;
            sel      = 2'(n % 4);
            for (int i = 0; i < WORDS; i++)
                exp[i*32 +: 32] = {right[i*16 +: 16], lo_half[i*16 +: 16]};
            apply_and_check("R6 unpacked line", exp);
        end

        // R9: pack in the bench, rebuild, compare with the original
        for (int n = 0; n < 400; n++) begin
            int cnt;
            logic [3:0] kind;
            cnt = 0;
            flags = '0; sign = '0; slots = '0; right = '0;
            lo_half = {$urandom, $urandom};
            for (int i = 0; i < WORDS; i++) begin
                kind = 4'($urandom % 4);
                up[i] = (kind == 0) ? 16'h0000 : (kind == 1) ? 16'hFFFF : 16'($urandom);
                exp[i*32 +: 32] = {up[i], lo_half[i*16 +: 16]};
                right[i*16 +: 16] = up[i];
                if (up[i] != 16'h0000 && up[i] != 16'hFFFF) begin
                    flags[i] = 1'b1;
                    if (cnt < SLOTS) slots[cnt*16 +: 16] = up[i];
                    cnt++;
                end else begin
                    sign[i] = up[i][15];
                end
            end
            packed_l = (cnt <= SLOTS);
            if (packed_l) right = {$urandom, $urandom};
            sel = 2'($urandom);
            apply_and_check("R9 round trip", exp);
        end

        // R1: reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(line_o == '0 && word_o == '0 && right_needed == 1'b0, "R1 reset re-entry",
            {line_o[95:0], word_o}, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule